// File: doc/BRIEF.md
# QDR SRAM Read/Write Command Sequencer

This block sits between the front-end command queues of a quad-data-rate SRAM controller and the physical I/O. It takes pending read and write commands from the queues and turns them into the memory's active-low read-select and write-select strobes. It also drives the shared address bus. The memory has separate data-in and data-out ports, so reads and writes can run in the same cycles. The address bus is given as two halves, one per clock edge, for the output serializer.

The block keeps the memory in its active power mode. After reset it sends only filler (dummy) read and write cycles at a fixed filler address for a long startup window. After startup it sends fillers in every cycle where no real command can go. A static mode input picks the burst length. In burst-2 mode one read and one write can go out in the same cycle, on opposite edges of the address bus. In burst-4 mode the cycles alternate between a read slot and a write slot, and a command waits for a slot of its own type. The block also marks when read data returns and when write data must be launched. It never marks read data from a filler read as valid.

Top module: `qseq_sequencer`

## Requirements
- R1: While rst_n is low, both strobes are high (deselected), both address halves are zero, and rd_pop, wr_pop, seq_ready, rd_data_valid, wd_launch and wd_from_queue are all low.
- R2: After reset is released, no command is popped for the first STARTUP_CYCLES (default 10240) rising edges. seq_ready goes high right after the STARTUP_CYCLES-th edge and stays high until the next reset.
- R3: During startup, burst-2 mode drives a filler read and a filler write in every cycle (both strobes low, both halves at DUMMY_ADDR). Burst-4 mode drives a filler read after odd-numbered edges and a filler write after even-numbered edges, counting from edge 1 after reset.
- R4: After startup, a cycle with neither queue pending is filled: in burst-2 mode with a filler read and a filler write, and in burst-4 mode with a filler of the current slot's type. All address halves are at DUMMY_ADDR.
- R5: In burst-2 mode, with both queues pending, both are popped at the same edge. After that edge both strobes are low, the rising-edge half carries the read address and the falling-edge half carries the write address.
- R6: In burst-2 mode, with only one queue pending, only that queue is popped and only its strobe goes low. The other strobe stays high and its address half is DUMMY_ADDR.
- R7: In burst-4 mode, read slots (odd edges after reset) and write slots (even edges) alternate. A strobe is never low in two cycles in a row, and the two strobes are never low in the same cycle.
- R8: In burst-4 mode, a command whose type does not match the current slot stays in its queue and is not popped. If the matching queue is empty, both strobes stay high in that cycle.
- R9: In burst-4 mode the address is single-data-rate: both halves carry the address of the command issued in that cycle.
- R10: rd_data_valid is high exactly READ_LAT (default 2) cycles after a cycle with a real read strobe. It is never high for a filler read.
- R11: wd_launch is high WRITE_LAT (default 1) cycles after any write strobe. wd_from_queue is high in the same cycle only when that write was a real one.
- R12: A reset during traffic returns the block to the full startup sequence of R2 and R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| burst4_mode | input | 1 | 1 selects burst-4 slots, 0 selects burst-2; change only during reset |
| rd_pending | input | 1 | Read queue has a command at its head |
| rd_addr | input | ADDR_W | Address at the head of the read queue |
| rd_pop | output | 1 | Read head is taken at this edge |
| wr_pending | input | 1 | Write queue has a command at its head |
| wr_addr | input | ADDR_W | Address at the head of the write queue |
| wr_pop | output | 1 | Write head is taken at this edge |
| seq_ready | output | 1 | Startup window is over |
| mem_rd_sel_n | output | 1 | Read-select strobe, active low |
| mem_wr_sel_n | output | 1 | Write-select strobe, active low |
| mem_addr_rise | output | ADDR_W | Address half for the rising clock edge |
| mem_addr_fall | output | ADDR_W | Address half for the falling clock edge |
| rd_data_valid | output | 1 | Read data from a real read is returning |
| wd_launch | output | 1 | Write data burst must be driven now |
| wd_from_queue | output | 1 | The burst being launched belongs to a real write |

## Verification
In burst-2 mode a real read and a real write can be issued in the same cycle, and they then share one address bus split across the two edges. The bench provokes this by holding both queues pending with different random addresses. It judges each edge half against the queue heads that its own model says were popped. In burst-4 mode the risky overlap is a pending command meeting a slot of the other type. Runs with only reads, only writes and random gating show whether the command is held without a pop while fillers and latency markers stay correct.

// File: rtl/qseq_pkg.sv
package qseq_pkg;

    // Issued command pair: bit 1 = write, bit 0 = read. The strobes are the
    // active-low inverse of these bits.
    typedef enum logic [1:0] {
        CMD_IDLE  = 2'b00,
        CMD_READ  = 2'b01,
        CMD_WRITE = 2'b10,
        CMD_BOTH  = 2'b11
    } cmd_pair_e;

    // Burst-4 slot owner for the coming edge.
    typedef enum logic {
        SLOT_RD = 1'b0,
        SLOT_WR = 1'b1
    } slot_e;

endpackage

// File: rtl/qseq_startup.sv
module qseq_startup #(
    parameter int STARTUP_CYCLES = 10240
) (
    input  logic clk,
    input  logic rst_n,
    output logic ready
);
    localparam int CNT_W = $clog2(STARTUP_CYCLES + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ready;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.ready) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
            if (st_q.cnt == CNT_W'(STARTUP_CYCLES - 1)) begin
                st_d.ready = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ready = st_q.ready;

    // R2
    ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ready |=> st_q.ready);

endmodule

// File: rtl/qseq_latency_pipe.sv
module qseq_latency_pipe #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [DEPTH-1:0] pipe_d, pipe_q;

    generate
        if (DEPTH == 1) begin : g_single
            always_comb pipe_d = din;
        end else begin : g_chain
            always_comb pipe_d = {pipe_q[DEPTH-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign dout = pipe_q[DEPTH-1];

endmodule

// File: rtl/qseq_arbiter.sv
module qseq_arbiter
    import qseq_pkg::*;
#(
    parameter int              ADDR_W     = 20,
    parameter logic [ADDR_W-1:0] DUMMY_ADDR = '0
) (
    input  logic              burst4,
    input  logic              ready,
    input  slot_e             slot,
    input  logic              rd_pending,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              wr_pending,
    input  logic [ADDR_W-1:0] wr_addr,
    output cmd_pair_e         cmd,
    output logic              rd_real,
    output logic              wr_real,
    output logic [ADDR_W-1:0] addr_r,
    output logic [ADDR_W-1:0] addr_f
);
    logic rd_sel, wr_sel;

    always_comb begin
        rd_sel  = 1'b0;
        wr_sel  = 1'b0;
        rd_real = 1'b0;
        wr_real = 1'b0;
        addr_r  = DUMMY_ADDR;
        addr_f  = DUMMY_ADDR;
        if (!burst4) begin
            if (!ready || (!rd_pending && !wr_pending)) begin
                rd_sel = 1'b1;
                wr_sel = 1'b1;
            end else begin
                if (rd_pending) begin
                    rd_sel  = 1'b1;
                    rd_real = 1'b1;
                    addr_r  = rd_addr;
                end
                if (wr_pending) begin
                    wr_sel  = 1'b1;
                    wr_real = 1'b1;
                    addr_f  = wr_addr;
                end
            end
        end else if (slot == SLOT_RD) begin
            if (ready && rd_pending) begin
                rd_sel  = 1'b1;
                rd_real = 1'b1;
                addr_r  = rd_addr;
                addr_f  = rd_addr;
            end else if (!ready || !wr_pending) begin
                rd_sel = 1'b1;
            end
        end else begin
            if (ready && wr_pending) begin
                wr_sel  = 1'b1;
                wr_real = 1'b1;
                addr_r  = wr_addr;
                addr_f  = wr_addr;
            end else if (!ready || !rd_pending) begin
                wr_sel = 1'b1;
            end
        end
        cmd = cmd_pair_e'({wr_sel, rd_sel});
    end

endmodule

// File: rtl/qseq_sequencer.sv
module qseq_sequencer
    import qseq_pkg::*;
#(
    parameter int                ADDR_W         = 20,
    parameter int                STARTUP_CYCLES = 10240,
    parameter int                READ_LAT       = 2,
    parameter int                WRITE_LAT      = 1,
    parameter logic [ADDR_W-1:0] DUMMY_ADDR     = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              burst4_mode,
    input  logic              rd_pending,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_pop,
    input  logic              wr_pending,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic              wr_pop,
    output logic              seq_ready,
    output logic              mem_rd_sel_n,
    output logic              mem_wr_sel_n,
    output logic [ADDR_W-1:0] mem_addr_rise,
    output logic [ADDR_W-1:0] mem_addr_fall,
    output logic              rd_data_valid,
    output logic              wd_launch,
    output logic              wd_from_queue
);
    localparam int RD_DEPTH = READ_LAT + 1;
    localparam int WR_DEPTH = WRITE_LAT + 1;

    typedef struct packed {
        slot_e             slot;
        logic              rps_n;
        logic              wps_n;
        logic [ADDR_W-1:0] addr_r;
        logic [ADDR_W-1:0] addr_f;
    } st_t;

    st_t               st_d, st_q;
    logic              ready;
    cmd_pair_e         cmd;
    logic              rd_real, wr_real;
    logic [ADDR_W-1:0] nxt_addr_r, nxt_addr_f;

    qseq_startup #(.STARTUP_CYCLES(STARTUP_CYCLES)) u_startup (
        .clk   (clk),
        .rst_n (rst_n),
        .ready (ready)
    );

    qseq_arbiter #(.ADDR_W(ADDR_W), .DUMMY_ADDR(DUMMY_ADDR)) u_arb (
        .burst4     (burst4_mode),
        .ready      (ready),
        .slot       (st_q.slot),
        .rd_pending (rd_pending),
        .rd_addr    (rd_addr),
        .wr_pending (wr_pending),
        .wr_addr    (wr_addr),
        .cmd        (cmd),
        .rd_real    (rd_real),
        .wr_real    (wr_real),
        .addr_r     (nxt_addr_r),
        .addr_f     (nxt_addr_f)
    );

    always_comb begin
        st_d        = st_q;
        st_d.slot   = (st_q.slot == SLOT_RD) ? SLOT_WR : SLOT_RD;
        st_d.rps_n  = ~cmd[0];
        st_d.wps_n  = ~cmd[1];
        st_d.addr_r = nxt_addr_r;
        st_d.addr_f = nxt_addr_f;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.slot  <= SLOT_RD;
            st_q.rps_n <= 1'b1;
            st_q.wps_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    qseq_latency_pipe #(.DEPTH(RD_DEPTH)) u_rd_pipe (
        .clk(clk), .rst_n(rst_n), .din(rd_real), .dout(rd_data_valid)
    );
    qseq_latency_pipe #(.DEPTH(WR_DEPTH)) u_wl_pipe (
        .clk(clk), .rst_n(rst_n), .din(cmd[1]), .dout(wd_launch)
    );
    qseq_latency_pipe #(.DEPTH(WR_DEPTH)) u_wq_pipe (
        .clk(clk), .rst_n(rst_n), .din(wr_real), .dout(wd_from_queue)
    );

    assign rd_pop        = rd_real;
    assign wr_pop        = wr_real;
    assign seq_ready     = ready;
    assign mem_rd_sel_n  = st_q.rps_n;
    assign mem_wr_sel_n  = st_q.wps_n;
    assign mem_addr_rise = st_q.addr_r;
    assign mem_addr_fall = st_q.addr_f;

    // R2
    no_early_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_ready |-> (!rd_pop && !wr_pop));

    // R4
    idle_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_ready && !burst4_mode && !rd_pending && !wr_pending) |=>
        (!mem_rd_sel_n && !mem_wr_sel_n &&
         mem_addr_rise == DUMMY_ADDR && mem_addr_fall == DUMMY_ADDR));

    // R5
    dual_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!burst4_mode && rd_pop && wr_pop) |=>
        (!mem_rd_sel_n && !mem_wr_sel_n &&
         mem_addr_rise == $past(rd_addr) && mem_addr_fall == $past(wr_addr)));

    // R7
    rd_alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (burst4_mode && !mem_rd_sel_n) |=> mem_rd_sel_n);

    // R7
    wr_alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (burst4_mode && !mem_wr_sel_n) |=> mem_wr_sel_n);

    // R8
    slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (burst4_mode && seq_ready && wr_pending && !rd_pending && !mem_wr_sel_n) |=>
        (mem_wr_sel_n && mem_rd_sel_n));

    // R9
    sdr_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (burst4_mode && rd_pop) |=>
        (mem_addr_rise == $past(rd_addr) && mem_addr_fall == $past(rd_addr)));

    // R11
    real_write_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wd_from_queue |-> wd_launch);

    generate
        if (READ_LAT == 2) begin : g_rd_lat_chk
            // R10
            rd_valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
                rd_data_valid |-> $past(rd_pop, 3));
        end
    endgenerate

endmodule

// File: tb/sim_qseq_sequencer.sv
`timescale 1ns/1ps
module sim_qseq_sequencer;
    localparam int AW      = 20;
    localparam int STARTUP = 10240;
    localparam int QN      = 1024;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          burst4_mode = 1'b0;
    logic          rd_pending = 1'b0, wr_pending = 1'b0;
    logic [AW-1:0] rd_addr = '0, wr_addr = '0;
    logic          rd_pop, wr_pop, seq_ready;
    logic          mem_rd_sel_n, mem_wr_sel_n;
    logic [AW-1:0] mem_addr_rise, mem_addr_fall;
    logic          rd_data_valid, wd_launch, wd_from_queue;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 0;

    logic [AW-1:0] rq [QN];
    logic [AW-1:0] wq [QN];
    int rd_head = 0, wr_head = 0;
    bit gate_r = 0, gate_w = 0;
    bit rand_gate = 0;
    string cur_req = "R3";

    // behavioural model state
    int  m_edges;
    bit  m_ready;
    bit  e_rsel, e_wsel;
    logic [AW-1:0] e_ar, e_af;
    bit  hr0, hr1, hr2, hw0, hw1, hq0, hq1;
    bit  d_rsel, d_wsel, d_rreal, d_wreal;
    logic [AW-1:0] d_ar, d_af;

    always #10 clk = ~clk;

    qseq_sequencer #(.ADDR_W(AW), .STARTUP_CYCLES(STARTUP)) u0 (
        .clk(clk), .rst_n(rst_n), .burst4_mode(burst4_mode),
        .rd_pending(rd_pending), .rd_addr(rd_addr), .rd_pop(rd_pop),
        .wr_pending(wr_pending), .wr_addr(wr_addr), .wr_pop(wr_pop),
        .seq_ready(seq_ready), .mem_rd_sel_n(mem_rd_sel_n), .mem_wr_sel_n(mem_wr_sel_n),
        .mem_addr_rise(mem_addr_rise), .mem_addr_fall(mem_addr_fall),
        .rd_data_valid(rd_data_valid), .wd_launch(wd_launch), .wd_from_queue(wd_from_queue)
    );

    task automatic chk(string req, string what, logic [AW-1:0] act, logic [AW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    task automatic model_clear();
        m_edges = 0; m_ready = 0;
        e_rsel = 0; e_wsel = 0; e_ar = '0; e_af = '0;
        hr0 = 0; hr1 = 0; hr2 = 0; hw0 = 0; hw1 = 0; hq0 = 0; hq1 = 0;
    endtask

    // Decision for the coming edge, from the requirements.
    task automatic decide();
        bit rp = rd_pending, wp = wr_pending;
        bit rd_turn = (m_edges % 2) == 0;  // edge number m_edges+1 is odd
        d_rsel = 0; d_wsel = 0; d_rreal = 0; d_wreal = 0; d_ar = '0; d_af = '0;
        if (!burst4_mode) begin
            if (m_ready && (rp || wp)) begin
                d_rreal = rp; d_rsel = rp; d_wreal = wp; d_wsel = wp;
                if (rp) d_ar = rd_addr;
                if (wp) d_af = wr_addr;
            end else begin
                d_rsel = 1; d_wsel = 1;
            end
        end else begin
            if (m_ready && rd_turn && rp) begin
                d_rsel = 1; d_rreal = 1; d_ar = rd_addr; d_af = rd_addr;
            end else if (m_ready && !rd_turn && wp) begin
                d_wsel = 1; d_wreal = 1; d_ar = wr_addr; d_af = wr_addr;
            end else if (!m_ready || !(rp || wp)) begin
                if (rd_turn) d_rsel = 1; else d_wsel = 1;
            end
        end
    endtask

    task automatic do_reset(bit mode, string req);
        @(negedge clk);
        rst_n = 0; rd_pending = 0; wr_pending = 0;
        burst4_mode = mode;
        model_clear();
        repeat (3) begin
            @(negedge clk);
            chk(req, "rd_sel_n in reset", mem_rd_sel_n, 1);
            chk(req, "wr_sel_n in reset", mem_wr_sel_n, 1);
            chk(req, "addr_rise in reset", mem_addr_rise, 0);
            chk(req, "addr_fall in reset", mem_addr_fall, 0);
            chk(req, "pops in reset", {rd_pop, wr_pop, seq_ready}, 0);
            chk(req, "markers in reset", {rd_data_valid, wd_launch, wd_from_queue}, 0);
        end
        rst_n = 1;
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) begin
            bit gr = gate_r, gw = gate_w;
            if (rand_gate) begin gr = $urandom_range(1, 0); gw = $urandom_range(1, 0); end
            rd_pending = gr && (rd_head < QN);
            wr_pending = gw && (wr_head < QN);
            rd_addr = rq[rd_head % QN];
            wr_addr = wq[wr_head % QN];
            #2;
            decide();
            chk(m_ready ? cur_req : "R2", "rd_pop", rd_pop, d_rreal);
            chk(m_ready ? cur_req : "R2", "wr_pop", wr_pop, d_wreal);
            @(posedge clk);
            if (d_rreal) rd_head++;
            if (d_wreal) wr_head++;
            e_rsel = d_rsel; e_wsel = d_wsel; e_ar = d_ar; e_af = d_af;
            hr2 = hr1; hr1 = hr0; hr0 = d_rreal;
            hw1 = hw0; hw0 = d_wsel;
            hq1 = hq0; hq0 = d_wreal;
            m_edges++;
            if (m_edges == STARTUP) m_ready = 1;
            @(negedge clk);
            chk(cur_req, "rd_sel_n", mem_rd_sel_n, !e_rsel);
            chk(cur_req, "wr_sel_n", mem_wr_sel_n, !e_wsel);
            chk(burst4_mode ? "R9" : cur_req, "addr_rise", mem_addr_rise, e_ar);
            chk(burst4_mode ? "R9" : cur_req, "addr_fall", mem_addr_fall, e_af);
            chk("R2", "seq_ready", seq_ready, m_ready);
            chk("R10", "rd_data_valid", rd_data_valid, hr2);
            chk("R11", "wd_launch", wd_launch, hw1);
            chk("R11", "wd_from_queue", wd_from_queue, hq1);
        end
    endtask

    task automatic mode_pass(bit mode);
        do_reset(mode, "R1");
        cur_req = "R3"; gate_r = 1; gate_w = 1; rand_gate = 0;
        run(STARTUP);
        cur_req = mode ? "R7" : "R5"; run(40);
        cur_req = mode ? "R8" : "R6"; gate_w = 0; run(30);
        gate_r = 0; gate_w = 1; run(30);
        cur_req = "R4"; gate_w = 0; run(40);
        cur_req = mode ? "R9" : "R5"; rand_gate = 1; run(200);
        do_reset(mode, "R12");
        cur_req = "R12"; rand_gate = 0; gate_r = 1; gate_w = 1;
        run(STARTUP + 30);
    endtask

    initial begin
        for (int i = 0; i < QN; i++) begin
            rq[i] = AW'($urandom);
            wq[i] = AW'($urandom);
        end
        mode_pass(1'b0);
        rd_head = 0; wr_head = 0;
        mode_pass(1'b1);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            bad++; total++;
            $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule